// File: doc/BRIEF.md
# Banked Program Memory Address Unit

This block drives the word address of a 16-bit-wide instruction ROM that is split into eight banks of 8192 words. It keeps the 13-bit program counter, a bank select register with a per-bit direction mask, and an 8-bit table pointer. Each cycle it picks one address source: the next sequential instruction, a timer interrupt vector, one of two table-read forms, or a direct wavetable start address. The chosen address is registered onto `rom_addr_o`. The ROM answers one cycle later on `rom_data_i`.

A table read takes two cycles. In the first cycle the table address is issued and the unit goes busy. In the second cycle the returned word is split: the low byte goes to `tbl_lo_o` with a one-cycle valid pulse, and the high byte goes to a read-only table-high register. The program counter does not move during a table read. A value written to the bank select register reaches the address bus only at the next sequential fetch.

Top module: `pmau_top`

## Requirements
- R1: A synchronous reset sets `rom_addr_o`, `pc_o`, `bank_o`, `tblp_o`, `tblh_o` and `tbl_lo_o` to 0, sets all three bank direction bits to 1, and clears both pending timer requests.
- R2: A sequential fetch (`fetch_i` when idle, no table or wavetable strobe, no vector taken) registers `{B, pc}` onto `rom_addr_o`, where B is the effective bank. It then sets `pc_o` to pc+1, wrapping modulo 8192.
- R3: A write to register 14h sets the bank select value from data bits [2:0]. A write to 15h sets the direction mask from bits [2:0]. The effective bank is select AND NOT direction. `bank_o` takes the effective bank only on a sequential fetch and holds otherwise.
- R4: A timer 0 request jumps to in-bank word 008h, and a timer 1 request jumps to 00Ch. Either jump is latched as pending and taken on a fetch, using the current `bank_o`. On the jump `pc_o` becomes the vector + 1, and `int_ack_o` pulses the serviced bit.
- R5: When both requests are pending, timer 0 is served first. The jump clears only the serviced request, and the other is taken at a later fetch.
- R6: While `int_en_i` is 0 or `stack_full_i` is 1, no vector is taken. The fetch is then sequential, and the pending requests are kept.
- R7: The current-page table strobe issues `{bank_o, pc_o[12:8], tblp}`.
- R8: The last-page table strobe issues `{bank_o, 5'b11111, tblp}`.
- R9: A table read holds `busy_o` high for exactly one cycle. During that cycle `pc_o` and `rom_addr_o` stay the same and every strobe is ignored. At its end `tblh_o` takes `rom_data_i[15:8]`, `tbl_lo_o` takes `rom_data_i[7:0]`, and `tbl_vld_o` pulses.
- R10: The table pointer is written at register 07h and shows on `tblp_o`. Writes to 08h are ignored. `tblh_o` changes only at the end of a table read.
- R11: The wavetable strobe registers `wave_start_i` onto `rom_addr_o` unchanged. It leaves `pc_o` and `bank_o` as they are.
- R12: When idle, simultaneous strobes are served in this order: current-page table, last-page table, wavetable, fetch. Register writes apply in every cycle, but they act only on addresses issued in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_i | input | 1 | Instruction fetch strobe |
| tbl_cur_i | input | 1 | Current-page table read strobe |
| tbl_last_i | input | 1 | Last-page table read strobe |
| wave_i | input | 1 | Wavetable address strobe |
| wave_start_i | input | 16 | Wavetable start address |
| tmr_req_i | input | 2 | Timer overflow requests, bit 0 = timer 0 |
| int_en_i | input | 1 | Interrupt enable |
| stack_full_i | input | 1 | Return stack full |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register write address |
| reg_wdata_i | input | 8 | Register write data |
| rom_data_i | input | 16 | ROM word for the previous address |
| rom_addr_o | output | 16 | Registered ROM address |
| pc_o | output | 13 | Program counter |
| bank_o | output | 3 | Active bank |
| tblp_o | output | 8 | Table pointer |
| tblh_o | output | 8 | Table-high register |
| tbl_lo_o | output | 8 | Low byte of the last table word |
| tbl_vld_o | output | 1 | Low byte valid pulse |
| busy_o | output | 1 | Second cycle of a table read |
| int_ack_o | output | 2 | One-cycle vector-taken pulse per timer |

## Verification
Address, program counter, bank, acknowledge and table-pointer results are due one clock edge after the strobe or write that causes them. The table-high byte, the low byte and its valid pulse are due one edge later, once the ROM word for the issued address has returned. A pending timer request is seen only from the edge after it arrives. The bench feeds a computed ROM word back from the registered address and advances a cycle-accurate model at each rising edge. It compares every output at the following falling edge, so each result is sampled exactly in the cycle it becomes due.

// File: rtl/pmau_pkg.sv
package pmau_pkg;
  localparam int REG_AW = 8;
  localparam logic [REG_AW-1:0] REG_TBLP  = 8'h07;
  localparam logic [REG_AW-1:0] REG_TBLH  = 8'h08;
  localparam logic [REG_AW-1:0] REG_BSEL  = 8'h14;
  localparam logic [REG_AW-1:0] REG_BDIR  = 8'h15;

  typedef enum logic {TS_IDLE, TS_READ} tstate_t;
endpackage

// File: rtl/pmau_bank.sv
module pmau_bank
  import pmau_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [REG_AW-1:0] waddr_i,
  input  logic [BANK_W-1:0] wdata_i,
  input  logic              commit_i,
  output logic [BANK_W-1:0] bank_eff_o,
  output logic [BANK_W-1:0] bank_cur_o
);
  logic [BANK_W-1:0] sel_q;
  logic [BANK_W-1:0] dir_q;

  // a direction bit of 1 (input) removes that bit from the bank
  assign bank_eff_o = sel_q & ~dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q      <= '0;
      dir_q      <= '1;
      bank_cur_o <= '0;
    end else begin
      if (we_i && waddr_i == REG_BSEL) sel_q <= wdata_i;
      if (we_i && waddr_i == REG_BDIR) dir_q <= wdata_i;
      if (commit_i) bank_cur_o <= bank_eff_o;
    end
  end
endmodule

// File: rtl/pmau_irq.sv
module pmau_irq #(
  parameter int NSRC     = 2,
  parameter int PC_W     = 13,
  parameter int VEC_BASE = 8,
  parameter int VEC_STEP = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req_i,
  input  logic            take_i,
  output logic            any_o,
  output logic [NSRC-1:0] grant_o,
  output logic [PC_W-1:0] vec_o
);
  logic [NSRC-1:0] pend_q;

  // lowest index wins
  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend_q[i] && !found) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_comb begin
    vec_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (grant_o[i]) vec_o = PC_W'(VEC_BASE + VEC_STEP * i);
    end
  end

  assign any_o = |pend_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q | req_i) & ~(take_i ? grant_o : '0);
  end
endmodule

// File: rtl/pmau_tbl.sv
module pmau_tbl
  import pmau_pkg::*;
#(
  parameter int PC_W   = 13,
  parameter int TP_W   = 8,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we_i,
  input  logic [REG_AW-1:0]      waddr_i,
  input  logic [TP_W-1:0]        wdata_i,
  input  logic                   start_i,
  input  logic                   last_i,
  input  logic [PC_W-TP_W-1:0]   pc_hi_i,
  input  logic [DATA_W-1:0]      rom_data_i,
  output logic [PC_W-1:0]        tbl_addr_o,
  output logic                   busy_o,
  output logic [TP_W-1:0]        tblp_o,
  output logic [DATA_W-TP_W-1:0] tblh_o,
  output logic [TP_W-1:0]        lo_o,
  output logic                   vld_o
);
  localparam int PAGE_W = PC_W - TP_W;

  tstate_t st_q;

  assign busy_o     = (st_q == TS_READ);
  assign tbl_addr_o = last_i ? {{PAGE_W{1'b1}}, tblp_o} : {pc_hi_i, tblp_o};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= TS_IDLE;
      tblp_o <= '0;
      tblh_o <= '0;
      lo_o   <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (we_i && waddr_i == REG_TBLP) tblp_o <= wdata_i;
      // the table-high register is not writable
      unique case (st_q)
        TS_IDLE: if (start_i) st_q <= TS_READ;
        TS_READ: begin
          tblh_o <= rom_data_i[DATA_W-1:TP_W];
          lo_o   <= rom_data_i[TP_W-1:0];
          vld_o  <= 1'b1;
          st_q   <= TS_IDLE;
        end
        default: st_q <= TS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pmau_top.sv
module pmau_top
  import pmau_pkg::*;
#(
  parameter int PC_W     = 13,
  parameter int BANK_W   = 3,
  parameter int TP_W     = 8,
  parameter int DATA_W   = 16,
  parameter int NSRC     = 2,
  parameter int VEC_BASE = 8,
  parameter int VEC_STEP = 4,
  localparam int ADDR_W  = BANK_W + PC_W,
  localparam int HB_W    = DATA_W - TP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_i,
  input  logic              tbl_cur_i,
  input  logic              tbl_last_i,
  input  logic              wave_i,
  input  logic [ADDR_W-1:0] wave_start_i,
  input  logic [NSRC-1:0]   tmr_req_i,
  input  logic              int_en_i,
  input  logic              stack_full_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [TP_W-1:0]   reg_wdata_i,
  input  logic [DATA_W-1:0] rom_data_i,
  output logic [ADDR_W-1:0] rom_addr_o,
  output logic [PC_W-1:0]   pc_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [TP_W-1:0]   tblp_o,
  output logic [HB_W-1:0]   tblh_o,
  output logic [TP_W-1:0]   tbl_lo_o,
  output logic              tbl_vld_o,
  output logic              busy_o,
  output logic [NSRC-1:0]   int_ack_o
);
  logic              idle;
  logic              do_tbl, do_wave, do_fetch, do_vec, do_seq;
  logic              irq_any;
  logic [NSRC-1:0]   irq_grant;
  logic [PC_W-1:0]   irq_vec;
  logic [PC_W-1:0]   tbl_addr;
  logic [BANK_W-1:0] bank_eff;

  assign idle     = !busy_o;
  assign do_tbl   = idle && (tbl_cur_i || tbl_last_i);
  assign do_wave  = idle && !tbl_cur_i && !tbl_last_i && wave_i;
  assign do_fetch = idle && !tbl_cur_i && !tbl_last_i && !wave_i && fetch_i;
  assign do_vec   = do_fetch && int_en_i && !stack_full_i && irq_any;
  assign do_seq   = do_fetch && !do_vec;

  pmau_bank #(.BANK_W(BANK_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .we_i      (reg_we_i),
    .waddr_i   (reg_addr_i),
    .wdata_i   (reg_wdata_i[BANK_W-1:0]),
    .commit_i  (do_seq),
    .bank_eff_o(bank_eff),
    .bank_cur_o(bank_o)
  );

  pmau_irq #(.NSRC(NSRC), .PC_W(PC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .req_i  (tmr_req_i),
    .take_i (do_vec),
    .any_o  (irq_any),
    .grant_o(irq_grant),
    .vec_o  (irq_vec)
  );

  pmau_tbl #(.PC_W(PC_W), .TP_W(TP_W), .DATA_W(DATA_W)) u_tbl (
    .clk       (clk),
    .rst       (rst),
    .we_i      (reg_we_i),
    .waddr_i   (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .start_i   (do_tbl),
    .last_i    (!tbl_cur_i),
    .pc_hi_i   (pc_o[PC_W-1:TP_W]),
    .rom_data_i(rom_data_i),
    .tbl_addr_o(tbl_addr),
    .busy_o    (busy_o),
    .tblp_o    (tblp_o),
    .tblh_o    (tblh_o),
    .lo_o      (tbl_lo_o),
    .vld_o     (tbl_vld_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr_o <= '0;
      pc_o       <= '0;
      int_ack_o  <= '0;
    end else begin
      int_ack_o <= '0;
      if (do_tbl) begin
        rom_addr_o <= {bank_o, tbl_addr};
      end else if (do_wave) begin
        rom_addr_o <= wave_start_i;
      end else if (do_vec) begin
        rom_addr_o <= {bank_o, irq_vec};
        pc_o       <= irq_vec + PC_W'(1);
        int_ack_o  <= irq_grant;
      end else if (do_seq) begin
        rom_addr_o <= {bank_eff, pc_o};
        pc_o       <= pc_o + PC_W'(1);
      end
    end
  end
endmodule

// File: rtl/pmau_chk.sv
module pmau_chk #(
  parameter int PC_W     = 13,
  parameter int BANK_W   = 3,
  parameter int NSRC     = 2,
  parameter int VEC_BASE = 8,
  parameter int VEC_STEP = 4,
  parameter int HB_W     = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     fetch_i,
  input logic                     int_en_i,
  input logic                     stack_full_i,
  input logic [BANK_W+PC_W-1:0]   rom_addr_o,
  input logic [PC_W-1:0]          pc_o,
  input logic [BANK_W-1:0]        bank_o,
  input logic [HB_W-1:0]          tblh_o,
  input logic                     tbl_vld_o,
  input logic                     busy_o,
  input logic [NSRC-1:0]          int_ack_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (rom_addr_o == '0 && pc_o == '0 && bank_o == '0 && tblh_o == '0));

  // R9
  busy_single_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> !busy_o);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> ($stable(pc_o) && $stable(rom_addr_o)));

  // R9
  vld_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    tbl_vld_o |-> $past(busy_o));

  // R10
  tblh_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |=> $stable(tblh_o));

  // R5
  ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(int_ack_o));

  // R6
  ack_cond_chk: assert property (@(posedge clk) disable iff (rst)
    (|int_ack_o) |-> $past(int_en_i && !stack_full_i && fetch_i));

  // R4
  vec0_addr_chk: assert property (@(posedge clk) disable iff (rst)
    int_ack_o[0] |-> (rom_addr_o[PC_W-1:0] == PC_W'(VEC_BASE)));

  // R4
  vec1_addr_chk: assert property (@(posedge clk) disable iff (rst)
    int_ack_o[1] |-> (rom_addr_o[PC_W-1:0] == PC_W'(VEC_BASE + VEC_STEP)));

  // R3
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch_i |=> $stable(bank_o));
endmodule

bind pmau_top pmau_chk #(
  .PC_W(PC_W), .BANK_W(BANK_W), .NSRC(NSRC),
  .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP), .HB_W(DATA_W - TP_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .fetch_i     (fetch_i),
  .int_en_i    (int_en_i),
  .stack_full_i(stack_full_i),
  .rom_addr_o  (rom_addr_o),
  .pc_o        (pc_o),
  .bank_o      (bank_o),
  .tblh_o      (tblh_o),
  .tbl_vld_o   (tbl_vld_o),
  .busy_o      (busy_o),
  .int_ack_o   (int_ack_o)
);

// File: tb/sim_pmau_top.sv
`timescale 1ns/1ps
module sim_pmau_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch = 1'b0, tc = 1'b0, tl = 1'b0, wv = 1'b0;
  logic [15:0] wstart = '0;
  logic [1:0]  req = '0;
  logic        ien = 1'b0, sfull = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  waddr = '0, wdata = '0;
  logic [15:0] rom_data;
  logic [15:0] a_addr;
  logic [12:0] a_pc;
  logic [2:0]  a_bank;
  logic [7:0]  a_tblp, a_tblh, a_lo;
  logic        a_vld, a_busy;
  logic [1:0]  a_ack;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // model state
  logic [15:0] m_addr;
  logic [12:0] m_pc;
  logic [2:0]  m_bank, m_bsel, m_bdir;
  logic [7:0]  m_tblp, m_tblh, m_lo;
  logic        m_vld, m_busy;
  logic [1:0]  m_p, m_ack;

  always #5 clk = ~clk;

  function automatic logic [15:0] romf(input logic [15:0] a);
    return (a * 16'h9E37) ^ 16'h5A3C;
  endfunction

  assign rom_data = romf(a_addr);

  pmau_top u0 (
    .clk(clk), .rst(rst), .fetch_i(fetch), .tbl_cur_i(tc), .tbl_last_i(tl),
    .wave_i(wv), .wave_start_i(wstart), .tmr_req_i(req), .int_en_i(ien),
    .stack_full_i(sfull), .reg_we_i(we), .reg_addr_i(waddr), .reg_wdata_i(wdata),
    .rom_data_i(rom_data), .rom_addr_o(a_addr), .pc_o(a_pc), .bank_o(a_bank),
    .tblp_o(a_tblp), .tblh_o(a_tblh), .tbl_lo_o(a_lo), .tbl_vld_o(a_vld),
    .busy_o(a_busy), .int_ack_o(a_ack)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    logic [1:0]  np, gr;
    logic [12:0] v;
    logic [2:0]  be;
    logic [15:0] w;
    logic        nv;
    logic [1:0]  na;
    @(posedge clk);
    if (rst) begin
      m_addr = '0; m_pc = '0; m_bank = '0; m_bsel = '0; m_bdir = 3'b111;
      m_tblp = '0; m_tblh = '0; m_lo = '0; m_vld = 1'b0; m_busy = 1'b0;
      m_p = '0; m_ack = '0;
    end else begin
      nv = 1'b0; na = '0;
      np = m_p | req;
      if (m_busy) begin
        w = romf(m_addr);
        m_tblh = w[15:8]; m_lo = w[7:0]; nv = 1'b1; m_busy = 1'b0;
      end else if (tc) begin
        m_addr = {m_bank, m_pc[12:8], m_tblp}; m_busy = 1'b1;
      end else if (tl) begin
        m_addr = {m_bank, 5'h1F, m_tblp}; m_busy = 1'b1;
      end else if (wv) begin
        m_addr = wstart;
      end else if (fetch) begin
        if (ien && !sfull && m_p != 2'b00) begin
          v  = m_p[0] ? 13'd8 : 13'd12;
          gr = m_p[0] ? 2'b01 : 2'b10;
          m_addr = {m_bank, v}; m_pc = v + 13'd1; na = gr; np = np & ~gr;
        end else begin
          be = m_bsel & ~m_bdir;
          m_addr = {be, m_pc}; m_bank = be; m_pc = m_pc + 13'd1;
        end
      end
      if (we) begin
        if (waddr == 8'h07) m_tblp = wdata;
        if (waddr == 8'h14) m_bsel = wdata[2:0];
        if (waddr == 8'h15) m_bdir = wdata[2:0];
      end
      m_p = np; m_vld = nv; m_ack = na;
    end
    @(negedge clk);
    chk(tag, "rom_addr", 32'(a_addr), 32'(m_addr));
    chk(tag, "pc", 32'(a_pc), 32'(m_pc));
    chk(tag, "bank", 32'(a_bank), 32'(m_bank));
    chk(tag, "tblp", 32'(a_tblp), 32'(m_tblp));
    chk(tag, "tblh", 32'(a_tblh), 32'(m_tblh));
    chk(tag, "tbl_lo", 32'(a_lo), 32'(m_lo));
    chk(tag, "tbl_vld", 32'(a_vld), 32'(m_vld));
    chk(tag, "busy", 32'(a_busy), 32'(m_busy));
    chk(tag, "int_ack", 32'(a_ack), 32'(m_ack));
    fetch = 1'b0; tc = 1'b0; tl = 1'b0; wv = 1'b0; we = 1'b0; req = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
    we = 1'b1; waddr = a; wdata = d;
    tick(tag);
  endtask

  initial begin
    logic [31:0] lf;
    // R1 reset state
    tick("R1"); tick("R1");
    rst = 1'b0;
    tick("R1");

    // R2 sequential fetch
    for (int i = 0; i < 6; i++) begin fetch = 1'b1; tick("R2"); end

    // R3 bank select with direction mask, deferred to next fetch
    wr(8'h14, 8'h05, "R3");
    fetch = 1'b1; tick("R3");
    wr(8'h15, 8'h00, "R3");
    tick("R3");
    fetch = 1'b1; tick("R3");
    wr(8'h14, 8'h07, "R3");
    wr(8'h15, 8'h02, "R3");
    wave_idle: begin fetch = 1'b1; tick("R3"); end
    wr(8'h14, 8'h03, "R3");
    wr(8'h15, 8'h00, "R3");
    fetch = 1'b1; tick("R3");

    // R7 R8 table addresses across the whole PC range, with PC wrap (R2)
    for (int i = 0; i < 8300; i++) begin
      fetch = 1'b1; tick("R2");
      if (i % 97 == 5) begin
        wr(8'h07, 8'(i * 37 + 11), "R10");
        tc = 1'b1; tick("R7"); tick("R9");
        tl = 1'b1; tick("R8"); tick("R9");
      end
    end

    // R10 write to table-high address is ignored
    wr(8'h08, 8'hEE, "R10");
    tick("R10");

    // R9 strobes during the busy cycle are ignored
    tc = 1'b1; tick("R9");
    fetch = 1'b1; wv = 1'b1; wstart = 16'h1357; tick("R9");
    tick("R9");

    // R12 priority among simultaneous strobes
    tc = 1'b1; tl = 1'b1; wv = 1'b1; fetch = 1'b1; tick("R12"); tick("R12");
    tl = 1'b1; wv = 1'b1; fetch = 1'b1; tick("R12"); tick("R12");
    wv = 1'b1; wstart = 16'hBEEF; fetch = 1'b1; tick("R12");

    // R11 wavetable addresses
    for (int i = 0; i < 40; i++) begin
      wv = 1'b1; wstart = 16'(i * 16'h0731 + 16'h00F0); tick("R11");
    end

    // R6 vectors blocked by enable and stack-full
    req = 2'b01; tick("R6");
    ien = 1'b0; fetch = 1'b1; tick("R6");
    ien = 1'b1; sfull = 1'b1; fetch = 1'b1; tick("R6");
    // R4 timer 0 vector once the stack has room
    sfull = 1'b0; fetch = 1'b1; tick("R4");
    fetch = 1'b1; tick("R4");
    // R4 timer 1 vector alone
    req = 2'b10; tick("R4");
    fetch = 1'b1; tick("R4");
    // R5 both pending: timer 0 first, then timer 1
    req = 2'b11; tick("R5");
    fetch = 1'b1; tick("R5");
    fetch = 1'b1; tick("R5");
    fetch = 1'b1; tick("R5");

    // R12 mixed traffic sweep from an LFSR
    lf = 32'hACE1_2468;
    for (int i = 0; i < 4000; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      fetch  = lf[0] | lf[1];
      tc     = lf[2] & lf[3] & lf[4];
      tl     = lf[5] & lf[6] & lf[7];
      wv     = lf[8] & lf[9] & lf[10];
      wstart = lf[31:16];
      req    = {lf[11] & lf[12] & lf[13], lf[14] & lf[15] & lf[16]};
      ien    = lf[17] | lf[18];
      sfull  = lf[19] & lf[20];
      we     = lf[21] & lf[22];
      case (lf[24:23])
        2'd0: waddr = 8'h07;
        2'd1: waddr = 8'h08;
        2'd2: waddr = 8'h14;
        default: waddr = 8'h15;
      endcase
      wdata = lf[31:24];
      tick("R12");
    end

    // R1 reset again mid-run
    rst = 1'b1; tick("R1");
    rst = 1'b0; tick("R1");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule